// File: doc/BRIEF.md
# UART Register Front End

This block is the software-visible side of a serial port. A host reaches it through a simple 32-bit bus. Each access uses a write strobe, a read strobe and a byte address. The block holds a 64-entry transmit FIFO and a 64-entry receive FIFO. It also holds a control word, an interrupt-threshold word and a baud word. A separate serial framing engine sits behind it. That engine takes bytes from the transmit FIFO, pushes received bytes into the receive FIFO and reports parity and framing errors. It reads the control and baud words from two output buses.

Software writes transmit bytes to one offset and reads received bytes from another. It polls a status word for the FIFO state and for sticky error flags. It can also let a single level-sensitive interrupt line signal when work is due. The error-clear and FIFO-reset controls are level bits. They act for as long as software keeps them set, and normal operation resumes once software writes them low again.

Top module: `uart_regif`

## Requirements
- R1: After reset the control, threshold and baud words read zero. The status word reads 0x0050_0000, meaning only receive-empty (bit 20) and transmit-empty (bit 22) are set. The irq output and tx_valid are low.
- R2: The byte offsets are 0x00 transmit data (write only), 0x04 receive data (read only), 0x08 control, 0x0C status (read only), 0x10 thresholds and 0x14 baud. Reads of any other offset, and reads of 0x00, return zero. Writes to any other offset, and writes to 0x0C, change nothing.
- R3: A write to offset 0x00 queues bits 7:0 of the write data. Queued bytes reach tx_data in write order. tx_valid is high only while control bit 12 (transmit enable) is set and the FIFO holds data. A byte leaves the FIFO in each cycle where tx_valid and tx_take are both high.
- R4: While control bit 13 (receive enable) is set, each rx_push cycle stores rx_data, and reads of offset 0x04 return the stored bytes in order in bits 7:0. With bit 13 clear, rx_push is ignored. A read of an empty receive FIFO returns zero and leaves the FIFO unchanged.
- R5: The transmit FIFO holds 64 bytes, and status bit 21 is set while it is full. A write while the FIFO is full is dropped and sets the sticky write-error flag, status bit 18.
- R6: A pulse on rx_par_err sets sticky status bit 16, and a pulse on rx_frm_err sets sticky status bit 17. Both flags stay set until they are cleared.
- R7: While control bit 24 is held high, status bits 16, 17 and 18 read zero and new error events are not captured. Once bit 24 is written low, error events set the flags again.
- R8: While control bit 22 is set, the transmit FIFO is held empty and writes to it are discarded. While control bit 23 is set, the receive FIFO is held empty.
- R9: irq is high whenever control bit 27 is set and the receive FIFO count is at least threshold bits 7:0.
- R10: irq is high whenever control bit 28 is set and the transmit FIFO count is below threshold bits 15:8. The threshold word stores bits 15:0 only, and its upper bits read zero.
- R11: Status bit 20 reflects receive-FIFO empty and bit 22 reflects transmit-FIFO empty, both updated the cycle after the change.
- R12: An rx_push that arrives while the receive FIFO already holds 64 bytes is dropped.
- R13: The outputs ctrl_word and baud_word always equal the stored control and baud words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, valid in the strobe cycle |
| tx_data | output | DW | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit byte available to the engine |
| tx_take | input | 1 | Engine consumes tx_data this cycle |
| rx_data | input | DW | Byte received by the engine |
| rx_push | input | 1 | Store rx_data this cycle |
| rx_par_err | input | 1 | Parity error event pulse |
| rx_frm_err | input | 1 | Framing error event pulse |
| ctrl_word | output | 32 | Stored control word for the engine |
| baud_word | output | 32 | Stored baud word for the engine |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: DEPTH of 64, ADDR_W of 5 and DW of 8. With a 64-entry depth, the bench can fill both FIFOs completely, so the full-write drop, the 65th receive push and a wrap of the read and write pointers are all reachable in a short run. A 5-bit address covers the unmapped offsets 0x18 and 0x1C and a misaligned offset, so the decode of every unused slot is exercised. Thresholds of 2 place both interrupt comparisons right at their boundary counts.

// File: rtl/uart_regif.sv
module uart_regif #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  input  logic              tx_take,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_push,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       baud_word,
  output logic              irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int MW = (CW > 8) ? CW : 8;
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_BAUD = ADDR_W'(5'h14);

  logic [31:0] ctrl, baud;
  logic [15:0] thr;
  logic        par_f, frm_f, wer_f;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire tx_en  = ctrl[12];
  wire rx_en  = ctrl[13];
  wire tx_rst = ctrl[22];
  wire rx_rst = ctrl[23];
  wire clr    = ctrl[24];
  wire rx_ie  = ctrl[27];
  wire tx_ie  = ctrl[28];

  wire tx_full  = (tx_cnt == CW'(DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == CW'(DEPTH));
  wire rx_empty = (rx_cnt == '0);

  wire tx_wr_req = bus_wr && (bus_addr == A_TX);
  wire tx_push   = tx_wr_req && !tx_full && !tx_rst;
  assign tx_valid = tx_en && !tx_empty && !tx_rst;
  wire tx_pop    = tx_valid && tx_take;
  assign tx_data = tx_mem[tx_rp];

  wire rx_push_ok = rx_push && rx_en && !rx_full && !rx_rst;
  wire rx_pop     = bus_rd && (bus_addr == A_RX) && !rx_empty && !rx_rst;

  assign ctrl_word = ctrl;
  assign baud_word = baud;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      thr  <= '0;
      baud <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl <= bus_wdata;
      if (bus_addr == A_THR)  thr  <= bus_wdata[15:0];
      if (bus_addr == A_BAUD) baud <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_push_ok) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (tx_push && !tx_pop)      tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_push && tx_pop) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_rst) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push_ok) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)     rx_rp <= rx_rp + 1'b1;
      if (rx_push_ok && !rx_pop)      rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_push_ok && rx_pop) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_f <= 1'b0; frm_f <= 1'b0; wer_f <= 1'b0;
    end else if (clr) begin
      par_f <= 1'b0; frm_f <= 1'b0; wer_f <= 1'b0;
    end else begin
      if (rx_par_err) par_f <= 1'b1;
      if (rx_frm_err) frm_f <= 1'b1;
      if (tx_wr_req && tx_full) wer_f <= 1'b1;
    end
  end

  wire [31:0] status = {9'b0, tx_empty, tx_full, rx_empty, 1'b0,
                        wer_f, frm_f, par_f, 16'b0};

  always_comb begin
    case (bus_addr)
      A_RX:    bus_rdata = rx_empty ? 32'b0 : 32'(rx_mem[rx_rp]);
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = status;
      A_THR:   bus_rdata = {16'b0, thr};
      A_BAUD:  bus_rdata = baud;
      default: bus_rdata = 32'b0;
    endcase
  end

  assign irq = (rx_ie && (MW'(rx_cnt) >= MW'(thr[7:0]))) ||
               (tx_ie && (MW'(tx_cnt) <  MW'(thr[15:8])));

  // R5
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_req && tx_full && !tx_pop && !clr && !tx_rst) |=> (tx_cnt == $past(tx_cnt)) && wer_f);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
  // R7
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !par_f && !frm_f && !wer_f);
  // R4
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RX && rx_empty && !rx_push_ok) |=> (rx_cnt == '0) && $stable(rx_rp));
  // R4
  rx_empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_RX && rx_empty) |-> bus_rdata == 32'b0);
  // R8
  fifo_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rst || rx_rst) |=> ((!$past(tx_rst) || tx_empty) && (!$past(rx_rst) || rx_empty)));
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ie || tx_ie));
endmodule

// File: tb/sim_uart_regif.sv
`timescale 1ns/1ps
module sim_uart_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_take = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_push = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic [31:0] ctrl_word, baud_word;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] txq[$];

  always #2 clk = ~clk;

  uart_regif u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_data(rx_data), .rx_push(rx_push), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .ctrl_word(ctrl_word), .baud_word(baud_word),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    txq.push_back(b);
    wr(5'h00, {24'hABCDEF, b});
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_data = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    tx_take = 1'b1;
    repeat (n) @(negedge clk);
    tx_take = 1'b0;
  endtask

  // monitor: compare every consumed transmit byte with the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_take) begin
      if (txq.size() == 0) chk("R3 unexpected tx byte", {24'b0, tx_data}, 32'hFFFF_FFFF);
      else chk("R3 tx order", {24'b0, tx_data}, {24'b0, txq.pop_front()});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h0C, v); chk("R1 status", v, 32'h0050_0000);
    rd(5'h08, v); chk("R1 ctrl", v, 0);
    rd(5'h10, v); chk("R1 thr", v, 0);
    rd(5'h14, v); chk("R1 baud", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);

    // R3 transmit order and enable
    send(8'h41); send(8'h42); send(8'hC3);
    chk("R3 valid gated by enable", {31'b0, tx_valid}, 0);
    wr(5'h08, 32'h0000_1000);
    #1 chk("R3 valid when enabled", {31'b0, tx_valid}, 1);
    drain(6);
    chk("R3 all bytes seen", txq.size(), 0);
    rd(5'h0C, v); chk("R11 tx empty after drain", v & 32'h0070_0000, 32'h0050_0000);

    // R5 full FIFO and dropped write
    for (int i = 0; i < 64; i++) send(8'h80 + 8'(i));
    rd(5'h0C, v); chk("R5 full flag", v & 32'h0074_0000, 32'h0030_0000);
    wr(5'h00, 32'hEE);
    rd(5'h0C, v); chk("R5 write error", v & 32'h0004_0000, 32'h0004_0000);
    drain(70);
    chk("R5 dropped byte absent", txq.size(), 0);

    // R7 level clear
    wr(5'h08, 32'h0100_1000);
    rd(5'h0C, v); chk("R7 cleared while held", v & 32'h0007_0000, 0);
    @(negedge clk); rx_par_err = 1'b1; @(negedge clk); rx_par_err = 1'b0;
    rd(5'h0C, v); chk("R7 no capture while held", v & 32'h0007_0000, 0);
    wr(5'h08, 32'h0000_1000);
    rd(5'h0C, v); chk("R7 still clear after release", v & 32'h0007_0000, 0);
    // R6 sticky flags
    @(negedge clk); rx_par_err = 1'b1; @(negedge clk); rx_par_err = 1'b0;
    rd(5'h0C, v); chk("R6 parity flag", v & 32'h0007_0000, 32'h0001_0000);
    @(negedge clk); rx_frm_err = 1'b1; @(negedge clk); rx_frm_err = 1'b0;
    repeat (3) @(negedge clk);
    rd(5'h0C, v); chk("R6 both sticky", v & 32'h0007_0000, 32'h0003_0000);

    // R4 receive path
    push_rx(8'h99);
    rd(5'h0C, v); chk("R4 push ignored when disabled", v & 32'h0010_0000, 32'h0010_0000);
    wr(5'h08, 32'h0000_3000);
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    rd(5'h0C, v); chk("R11 rx not empty", v & 32'h0010_0000, 0);
    rd(5'h04, v); chk("R4 rx byte 0", v, 32'h11);
    rd(5'h04, v); chk("R4 rx byte 1", v, 32'h22);
    rd(5'h04, v); chk("R4 rx byte 2", v, 32'h33);
    rd(5'h04, v); chk("R4 empty read zero", v, 0);
    push_rx(8'h5A);
    rd(5'h04, v); chk("R4 pointers unchanged by empty read", v, 32'h5A);

    // R12 receive overflow
    for (int i = 0; i < 65; i++) push_rx(8'(i));
    for (int i = 0; i < 64; i++) begin
      rd(5'h04, v); chk("R12 rx order at full", v, 32'(i));
    end
    rd(5'h04, v); chk("R12 extra byte dropped", v, 0);

    // R8 FIFO resets
    push_rx(8'h01); push_rx(8'h02);
    wr(5'h00, 32'h10); wr(5'h00, 32'h11);
    wr(5'h08, 32'h00C0_3000);
    rd(5'h0C, v); chk("R8 both held empty", v & 32'h0070_0000, 32'h0050_0000);
    wr(5'h00, 32'h12);
    rd(5'h0C, v); chk("R8 tx write discarded", v & 32'h0040_0000, 32'h0040_0000);
    wr(5'h08, 32'h0000_3000);
    rd(5'h0C, v); chk("R8 empty after release", v & 32'h0070_0000, 32'h0050_0000);
    rd(5'h04, v); chk("R8 rx data gone", v, 0);

    // R9 receive threshold
    wr(5'h10, 32'h0000_0202);
    wr(5'h08, 32'h0800_3000);
    chk("R9 irq low when empty", {31'b0, irq}, 0);
    push_rx(8'h77);
    chk("R9 irq low below threshold", {31'b0, irq}, 0);
    push_rx(8'h78);
    chk("R9 irq at threshold", {31'b0, irq}, 1);
    rd(5'h04, v); chk("R9 data", v, 32'h77);
    chk("R9 irq drops below", {31'b0, irq}, 0);
    rd(5'h04, v);

    // R10 transmit threshold
    wr(5'h08, 32'h1000_3000);
    chk("R10 irq when tx empty", {31'b0, irq}, 1);
    send(8'h61);
    chk("R10 irq at count 1", {31'b0, irq}, 1);
    send(8'h62);
    chk("R10 irq off at threshold", {31'b0, irq}, 0);
    drain(4);
    chk("R10 queue drained", txq.size(), 0);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R10 thr upper bits zero", v, 32'h0000_FFFF);

    // R2 / R13 decode and outputs
    wr(5'h14, 32'h0080_1234);
    rd(5'h14, v); chk("R2 baud readback", v, 32'h0080_1234);
    chk("R13 baud_word", baud_word, 32'h0080_1234);
    chk("R13 ctrl_word", ctrl_word, 32'h1000_3000);
    wr(5'h18, 32'hDEAD_BEEF);
    rd(5'h18, v); chk("R2 unmapped read", v, 0);
    rd(5'h1C, v); chk("R2 unmapped read 1C", v, 0);
    rd(5'h02, v); chk("R2 misaligned read", v, 0);
    rd(5'h00, v); chk("R2 tx offset reads zero", v, 0);
    rd(5'h08, v); chk("R2 ctrl untouched", v, 32'h1000_3000);
    rd(5'h0C, st);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R2 status write ignored", v, st);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule